// File: doc/BRIEF.md
# Configuration Memory CRC Scrubber with Test-Access Reference Register

This block watches a small configuration memory for silent corruption. It reads the memory in a continuous loop, one word per clock, and folds each word into a 32-bit CRC. At the end of each full pass it compares the result with a stored reference value. While the memory is being set up (load mode), every finished pass stores its CRC as the new reference. In operating mode (user mode), every finished pass compares against that reference and drives a registered error flag.

The reference sits behind a test-access data register. A test access port controller outside this block supplies the decoded instruction and the Capture, Shift and Update phase strobes. When the dedicated instruction is active in user mode, one capture/shift/update sequence reads out the current reference and writes a new one. An engineer can load a deliberately wrong value to prove that the error path works, and then restore the correct value, without reloading the memory. The block only reports. Reload or repair of the memory is left to the surrounding system.

Top module: `cfg_crc_scrub`

## Requirements
- R1: A synchronous reset clears `crc_error`, clears the reference register to zero and marks the reference invalid. While the reference is invalid, `crc_error` stays 0 in every mode.
- R2: The CRC of a pass uses polynomial 0x04C11DB7 and seed 0xFFFFFFFF, with no bit reflection and no final inversion. It covers addresses 0 to DEPTH-1 in ascending order, most significant data bit first. The block reads one word per clock, and memory read data arrives one clock after `mem_addr`.
- R3: In load mode (`cfg_mode` = 2'b01), every completed pass stores its CRC as the reference, marks the reference valid and clears `crc_error`.
- R4: In user mode (`cfg_mode` = 2'b10) with a valid reference, every completed pass sets `crc_error` to 1 if the pass CRC differs from the reference and to 0 otherwise. `crc_error` changes only at the end of a pass.
- R5: The test register is selected only when `tap_ir` equals 10'b00_0001_0101 and the mode is user. When it is not selected, `tap_tdo` is 0 and no TAP activity changes the reference.
- R6: On a rising `tap_tck` in the Capture phase, the selected register takes the reference. On each rising `tap_tck` in the Shift phase, it shifts toward bit 0, taking `tap_tdi` into bit 31. `tap_tdo` shows bit 0, so 32 shifts read the old reference out least significant bit first while the new value goes in.
- R7: The reference changes from the TAP only on a rising `tap_tck` in the Update phase, which also marks it valid. A capture and a partial shift with no update leave the reference unchanged.
- R8: After a wrong reference is written in user mode, `crc_error` becomes 1 at the end of the next full pass. After the correct value is written back, it returns to 0 at the end of the next full pass.
- R9: In the idle modes (2'b00 and 2'b11) no pass runs, `mem_addr` stays 0 and `crc_error` holds its value. Any mode change restarts the scan at address 0.
- R10: `mem_addr` always stays below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 01 load, 10 user, 00/11 idle |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, one clock after address |
| tap_tck | input | 1 | Test clock, oversampled by `clk` |
| tap_tdi | input | 1 | Test data in |
| tap_ir | input | IR_W | Decoded current instruction |
| tap_capture_dr | input | 1 | Controller is in Capture-DR |
| tap_shift_dr | input | 1 | Controller is in Shift-DR |
| tap_update_dr | input | 1 | Controller is in Update-DR |
| tap_tdo | output | 1 | Test data out |
| crc_error | output | 1 | Registered mismatch flag |

## Verification
A scan counter that skips or repeats a word, or a CRC register that is not reseeded between passes, gives a reference that the bench's own CRC of the memory does not match. This shows up at the first TAP readout after load. A reference that a stray TAP phase or a partial shift has overwritten shows up as a spurious `crc_error` at the end of the next pass, or as a wrong word on `tap_tdo` at the next readout. A stale error flag shows up within one pass after the memory or the reference is put right again.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  localparam logic [1:0] MODE_LOAD = 2'b01;
  localparam logic [1:0] MODE_USER = 2'b10;

  // one bit of a non-reflected CRC, MSB-first feedback
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/cc_scan.sv
module cc_scan
  import crc_chk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pass_done,
  output logic [CRC_W-1:0]  pass_crc
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  logic              last_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;

  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) r = crc_bit(r, d[i]);
    return r;
  endfunction

  assign crc_nxt   = crc_word(crc_q, mem_rdata);
  assign pass_done = vld_q && last_q && run && !restart;
  assign pass_crc  = crc_nxt;
  assign mem_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      crc_q  <= CRC_SEED;
    end else begin
      addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
      vld_q  <= 1'b1;
      last_q <= (addr_q == LAST_ADDR);
      if (vld_q) crc_q <= last_q ? CRC_SEED : crc_nxt;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(mem_addr) < DEPTH) else $error("address out of range"); // R10
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> (mem_addr == '0) || run) else $error("scan moved while idle"); // R9
endmodule

// File: rtl/cc_tap.sv
module cc_tap
  import crc_chk_pkg::*;
#(
  parameter int              IR_W    = 10,
  parameter logic [IR_W-1:0] IR_CODE = 10'b00_0001_0101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             user_mode,
  input  logic             tck,
  input  logic             tdi,
  input  logic [IR_W-1:0]  ir,
  input  logic             cap,
  input  logic             sh,
  input  logic             upd,
  input  logic [CRC_W-1:0] ref_in,
  output logic             tdo,
  output logic             upd_pulse,
  output logic [CRC_W-1:0] upd_value
);
  logic [2:0]       tck_sync;
  logic             tck_rise;
  logic             sel;
  logic [CRC_W-1:0] tdr_q;

  assign tck_rise  = tck_sync[1] && !tck_sync[2];
  assign sel       = user_mode && (ir == IR_CODE);
  assign upd_pulse = tck_rise && sel && upd;
  assign upd_value = tdr_q;
  assign tdo       = sel && tdr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_sync <= '0;
      tdr_q    <= '0;
    end else begin
      tck_sync <= {tck_sync[1:0], tck};
      if (tck_rise && sel) begin
        if (cap)     tdr_q <= ref_in;
        else if (sh) tdr_q <= {tdi, tdr_q[CRC_W-1:1]};
      end
    end
  end

  AST_TAP_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    tck_rise |-> $onehot0({cap, sh, upd})) else $error("overlapping TAP phases"); // R6
endmodule

// File: rtl/cfg_crc_scrub.sv
module cfg_crc_scrub
  import crc_chk_pkg::*;
#(
  parameter int              DEPTH   = 16,
  parameter int              DATA_W  = 32,
  parameter int              IR_W    = 10,
  parameter logic [IR_W-1:0] IR_CODE = 10'b00_0001_0101,
  parameter int              ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              tap_tck,
  input  logic              tap_tdi,
  input  logic [IR_W-1:0]   tap_ir,
  input  logic              tap_capture_dr,
  input  logic              tap_shift_dr,
  input  logic              tap_update_dr,
  output logic              tap_tdo,
  output logic              crc_error
);
  logic [1:0]       mode_q;
  logic             restart;
  logic             run;
  logic             in_load;
  logic             in_user;
  logic             pass_done;
  logic [CRC_W-1:0] pass_crc;
  logic             tap_upd;
  logic [CRC_W-1:0] tap_val;
  logic [CRC_W-1:0] ref_q;
  logic             ref_valid_q;
  logic             err_q;

  assign in_load   = (cfg_mode == MODE_LOAD);
  assign in_user   = (cfg_mode == MODE_USER);
  assign run       = in_load || in_user;
  assign restart   = (cfg_mode != mode_q);
  assign crc_error = err_q;

  cc_scan #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pass_done(pass_done), .pass_crc(pass_crc)
  );

  cc_tap #(.IR_W(IR_W), .IR_CODE(IR_CODE)) u_tap (
    .clk(clk), .rst(rst), .user_mode(in_user),
    .tck(tap_tck), .tdi(tap_tdi), .ir(tap_ir),
    .cap(tap_capture_dr), .sh(tap_shift_dr), .upd(tap_update_dr),
    .ref_in(ref_q), .tdo(tap_tdo), .upd_pulse(tap_upd), .upd_value(tap_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= 2'b00;
      ref_q       <= '0;
      ref_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      mode_q <= cfg_mode;
      if (pass_done && in_load) begin
        ref_q       <= pass_crc;
        ref_valid_q <= 1'b1;
        err_q       <= 1'b0;
      end else if (pass_done && in_user && ref_valid_q) begin
        err_q <= (pass_crc != ref_q);
      end
      if (tap_upd) begin
        ref_q       <= tap_val;
        ref_valid_q <= 1'b1;
      end
    end
  end

  AST_ERR_AT_PASS_END: assert property (@(posedge clk) disable iff (rst)
    !pass_done |=> $stable(crc_error)) else $error("error moved mid-pass"); // R4
  AST_NO_ERR_WITHOUT_REF: assert property (@(posedge clk) disable iff (rst)
    !ref_valid_q |-> !crc_error) else $error("error without reference"); // R1
  AST_TAP_USER_ONLY: assert property (@(posedge clk) disable iff (rst)
    !in_user |-> !tap_upd) else $error("update outside user mode"); // R5
  AST_REF_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (!tap_upd && !(pass_done && in_load)) |=> $stable(ref_q)) else $error("reference corrupted"); // R7
endmodule

// File: tb/tb_cfg_crc_scrub.sv
`timescale 1ns/1ps
module tb_cfg_crc_scrub;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int AW     = 4;
  localparam logic [9:0] SEL_IR = 10'b00_0001_0101;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cfg_mode;
  logic [AW-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic tck, tdi, cap, sh, upd;
  logic [9:0] ir;
  logic tdo, crc_error;

  logic [DATA_W-1:0] mem [DEPTH];
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  cfg_crc_scrub dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tap_tck(tck), .tap_tdi(tdi), .tap_ir(ir), .tap_capture_dr(cap), .tap_shift_dr(sh),
    .tap_update_dr(upd), .tap_tdo(tdo), .crc_error(crc_error)
  );

  function automatic logic [31:0] model_crc();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int a = 0; a < DEPTH; a++)
      for (int b = DATA_W - 1; b >= 0; b--)
        c = (c << 1) ^ ({32{c[31] ^ mem[a][b]}} & 32'h04C11DB7);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic passes(input int n);
    cyc(n * DEPTH + 6);
  endtask

  task automatic pulse();
    tck = 1'b1; cyc(4);
    tck = 1'b0; cyc(4);
  endtask

  task automatic tap_dr(input logic [31:0] din, input int nbits, input bit do_upd,
                        output logic [31:0] dout);
    dout = '0;
    cap = 1'b1; pulse(); cap = 1'b0;
    sh = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      pulse();
    end
    sh = 1'b0;
    if (do_upd) begin upd = 1'b1; pulse(); upd = 1'b0; end
  endtask

  task automatic fill_mem();
    for (int a = 0; a < DEPTH; a++) mem[a] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] exp, wrong, got;
    int w, bitn;
    bit seen_nz;
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_mode = 2'b00; tck = 0; tdi = 0; cap = 0; sh = 0; upd = 0; ir = SEL_IR;
    fill_mem();
    cyc(5);
    rst = 1'b0;
    cyc(1);
    check("R1 reset error", {31'b0, crc_error}, 32'd0);
    check("R5 tdo idle after reset", {31'b0, tdo}, 32'd0);

    seen_nz = 0;
    for (int i = 0; i < 40; i++) begin cyc(1); if (mem_addr != 0) seen_nz = 1; end
    check("R9 addr held in idle 00", {31'b0, seen_nz}, 32'd0);

    cfg_mode = 2'b10;
    passes(3);
    check("R1 no error before reference", {31'b0, crc_error}, 32'd0);
    tap_dr(32'h0, 32, 0, got);
    check("R1 reference zero after reset", got, 32'h0);

    for (int r = 0; r < 4; r++) begin
      cfg_mode = 2'b00; cyc(2);
      fill_mem();
      exp = model_crc();
      cfg_mode = 2'b01; passes(3);
      check("R3 load clears error", {31'b0, crc_error}, 32'd0);
      cfg_mode = 2'b10; passes(2);
      check("R4 clean memory no error", {31'b0, crc_error}, 32'd0);
      tap_dr(exp, 32, 1, got);
      check("R2 R6 captured reference", got, exp);
      wrong = exp ^ ($urandom | 32'd1);
      tap_dr(wrong, 32, 1, got);
      check("R6 readout during write", got, exp);
      passes(2);
      check("R8 wrong reference flags", {31'b0, crc_error}, 32'd1);
      tap_dr($urandom, 8, 0, got);
      passes(2);
      check("R7 partial shift keeps error", {31'b0, crc_error}, 32'd1);
      tap_dr(wrong, 32, 0, got);
      check("R7 partial shift keeps reference", got, wrong);
      tap_dr(exp, 32, 1, got);
      passes(2);
      check("R8 restored reference clears", {31'b0, crc_error}, 32'd0);
      w = $urandom_range(DEPTH - 1, 0);
      bitn = $urandom_range(DATA_W - 1, 0);
      mem[w][bitn] = ~mem[w][bitn];
      passes(2);
      check("R4 upset word flags", {31'b0, crc_error}, 32'd1);
      mem[w][bitn] = ~mem[w][bitn];
      passes(2);
      check("R4 repaired word clears", {31'b0, crc_error}, 32'd0);
    end

    exp = model_crc();
    tap_dr(~exp, 32, 1, got);
    passes(2);
    check("R8 inverted reference flags", {31'b0, crc_error}, 32'd1);
    cfg_mode = 2'b11;
    seen_nz = 0;
    for (int i = 0; i < 3 * DEPTH; i++) begin cyc(1); if (mem_addr != 0) seen_nz = 1; end
    check("R9 addr held in idle 11", {31'b0, seen_nz}, 32'd0);
    check("R9 error holds in idle", {31'b0, crc_error}, 32'd1);
    check("R5 tdo zero outside user", {31'b0, tdo}, 32'd0);
    tap_dr(exp, 32, 1, got);
    cfg_mode = 2'b10; passes(2);
    check("R5 idle write ignored", {31'b0, crc_error}, 32'd1);
    ir = 10'b00_0001_0110;
    tap_dr(exp, 32, 1, got);
    check("R5 tdo zero for other code", got, 32'h0);
    passes(2);
    check("R5 other code write ignored", {31'b0, crc_error}, 32'd1);
    ir = SEL_IR;
    tap_dr(exp, 32, 1, got);
    check("R6 readout of inverted value", got, ~exp);
    passes(2);
    check("R8 clears after fix", {31'b0, crc_error}, 32'd0);

    tap_dr(~exp, 32, 1, got);
    passes(2);
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    check("R1 reset clears error", {31'b0, crc_error}, 32'd0);
    passes(3);
    check("R1 user without load no error", {31'b0, crc_error}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule